// File: doc/BRIEF.md
# Three-Mode Clock Power Controller

This block decides where a processor subsystem's clocks come from and whether they run at all. It keeps one of three operating modes. In run mode the processor clock is taken from a PLL and the two bus clocks are integer fractions of it. In direct-run mode all three clocks are taken from the slow system clock. In halt mode the system clock and every derived clock are gated off. The controller itself runs from an always-on clock, so it can still detect wake events while halted.

Software drives the block through a single write port that carries every control field at once: a run-select bit, a stop-request bit, a PLL enable bit and two bus divisors. Run and halt can never follow each other directly: leaving run always lands in direct-run, and a wake from halt always lands in direct-run. From direct-run the block moves on to run only once the PLL reports lock. The PLL enable and the divisors may change only while direct-run is the active mode. Wake inputs are synchronised, reduced to rising edges and filtered by a per-input enable mask.

Top module: `clkpm_ctrl`

## Requirements
- R1: `mode_o` encodes direct-run as 0, run as 1 and halt as 2. After reset the mode is direct-run, `run_rd`, `stop_rd` and `pll_en_o` are 0, and the divisor registers hold `DEF_HDIV` and `DEF_PDIV`.
- R2: The mode never changes from run to halt or from halt to run in a single step. Each such move passes through direct-run for at least one cycle.
- R3: In run mode `cpu_src_pll_o` is 1, both gate enables are 1, and `hdiv_o` and `pdiv_o` show the programmed divisors.
- R4: In direct-run mode `cpu_src_pll_o` is 0, both gate enables are 1, and `hdiv_o` and `pdiv_o` are 1.
- R5: A write updates the PLL enable and the two divisors only when the mode is direct-run at the write. In any other mode those fields are left unchanged.
- R6: In halt mode `sysclk_en_o` and `clk_gate_en_o` are both 0, and `cpu_src_pll_o` is 0.
- R7: While halted, a rising edge on an enabled wake input returns the mode to direct-run within 4 cycles, even when the run bit is set. Run may follow only afterwards.
- R8: Clearing the run bit while in run leads to direct-run. A stop request that is armed while in direct-run leads to halt, and this takes priority over entering run.
- R9: Direct-run moves to run only when the run bit is set, the PLL enable is set and `pll_lock_i` is 1. Otherwise the mode stays in direct-run.
- R10: Wake inputs whose `wake_en_i` bit is 0 never wake the block. A wake input that is already high when halt is entered does not wake it; only a new rising edge does.
- R11: `stop_rd` stays 1 after a wake until software writes it to 0. Writing 1 over a stop bit that is already 1 does not arm a new halt. A write of 0 followed by a write of 1 does arm one.
- R12: A divisor field written as 0 is ignored, and the register keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Write strobe for all control fields |
| ctl_run | input | 1 | Run-select bit to write |
| ctl_stop | input | 1 | Stop-request bit to write |
| ctl_pll_on | input | 1 | PLL enable bit to write |
| ctl_hdiv | input | DIVW | Bus clock divisor to write |
| ctl_pdiv | input | DIVW | Peripheral bus divisor to write |
| run_rd | output | 1 | Current run-select bit |
| stop_rd | output | 1 | Current stop-request bit |
| pll_en_o | output | 1 | PLL enable |
| pll_lock_i | input | 1 | PLL lock indication |
| wake_evt_i | input | NWAKE | Asynchronous wake event lines |
| wake_en_i | input | NWAKE | Per-line wake enable mask |
| mode_o | output | 2 | Current mode (0 direct-run, 1 run, 2 halt) |
| cpu_src_pll_o | output | 1 | 1 selects the PLL as clock source |
| clk_gate_en_o | output | 1 | Enable for the processor and bus clock gates |
| sysclk_en_o | output | 1 | Enable for the system clock |
| hdiv_o | output | DIVW | Applied bus clock divisor |
| pdiv_o | output | DIVW | Applied peripheral bus divisor |

## Verification
The assertions take for granted three things about the inputs. `pll_lock_i` stays low while the PLL enable is low. Lock, once it is asserted, stays asserted in run mode. Each wake line holds a level for at least two controller cycles, so the synchroniser sees every edge. The bench meets these conditions with a PLL stub that raises lock a few cycles after the enable and drops it as soon as the enable falls. Wake pulses last three cycles, and random writes always keep the PLL enabled with fixed divisors.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;
  typedef enum logic [1:0] {
    MD_DIRECT = 2'd0,
    MD_RUN    = 2'd1,
    MD_HALT   = 2'd2
  } pm_mode_t;
endpackage

// File: rtl/clkpm_wake_det.sv
module clkpm_wake_det #(
  parameter int NWAKE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NWAKE-1:0] evt_i,
  input  logic [NWAKE-1:0] en_i,
  output logic             hit_o
);
  logic [NWAKE-1:0] edge_hit;

  // each line: two-flop synchroniser, then rising-edge detect
  for (genvar i = 0; i < NWAKE; i++) begin : g_line
    logic s1, s2, prev;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1   <= 1'b0;
        s2   <= 1'b0;
        prev <= 1'b0;
      end else begin
        s1   <= evt_i[i];
        s2   <= s1;
        prev <= s2;
      end
    end
    assign edge_hit[i] = s2 & ~prev & en_i[i];
  end

  assign hit_o = |edge_hit;

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (en_i == '0) |-> !hit_o); // R10
endmodule

// File: rtl/clkpm_ctl_regs.sv
module clkpm_ctl_regs
  import clkpm_pkg::*;
#(
  parameter int DIVW     = 4,
  parameter int DEF_HDIV = 2,
  parameter int DEF_PDIV = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_i,
  input  logic            run_i,
  input  logic            stop_i,
  input  logic            pll_i,
  input  logic [DIVW-1:0] hdiv_i,
  input  logic [DIVW-1:0] pdiv_i,
  input  pm_mode_t        mode_i,
  input  logic            halt_take_i,
  output logic            run_q,
  output logic            stop_q,
  output logic            armed_q,
  output logic            pll_en_q,
  output logic [DIVW-1:0] hdiv_q,
  output logic [DIVW-1:0] pdiv_q
);
  localparam logic [DIVW-1:0] HDIV_RST = DIVW'(DEF_HDIV);
  localparam logic [DIVW-1:0] PDIV_RST = DIVW'(DEF_PDIV);

  logic cfg_open;
  assign cfg_open = we_i && (mode_i == MD_DIRECT);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      stop_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (we_i) begin
        run_q   <= run_i;
        stop_q  <= stop_i;
        // arming needs a 0 -> 1 change of the stop bit
        armed_q <= stop_i & (armed_q | ~stop_q);
      end
      if (halt_take_i) armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pll_en_q <= 1'b0;
      hdiv_q   <= HDIV_RST;
      pdiv_q   <= PDIV_RST;
    end else if (cfg_open) begin
      pll_en_q <= pll_i;
      if (hdiv_i != '0) hdiv_q <= hdiv_i;
      if (pdiv_i != '0) pdiv_q <= pdiv_i;
    end
  end

  AST_PLL_DIRECT_ONLY: assert property (@(posedge clk) disable iff (rst)
    (mode_i != MD_DIRECT) |=> $stable(pll_en_q)); // R5
  AST_DIV_DIRECT_ONLY: assert property (@(posedge clk) disable iff (rst)
    (mode_i != MD_DIRECT) |=> ($stable(hdiv_q) && $stable(pdiv_q))); // R5
  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (hdiv_q != '0) && (pdiv_q != '0)); // R12
  AST_REARM_NEEDS_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_q) |-> !$past(stop_q)); // R11
endmodule

// File: rtl/clkpm_mode_fsm.sv
module clkpm_mode_fsm
  import clkpm_pkg::*;
#(
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run_q,
  input  logic            armed_q,
  input  logic            pll_en_q,
  input  logic            pll_lock_i,
  input  logic            wake_hit_i,
  input  logic [DIVW-1:0] hdiv_q,
  input  logic [DIVW-1:0] pdiv_q,
  output pm_mode_t        mode_q,
  output logic            halt_take_o,
  output logic            cpu_src_pll_o,
  output logic            clk_gate_en_o,
  output logic            sysclk_en_o,
  output logic [DIVW-1:0] hdiv_o,
  output logic [DIVW-1:0] pdiv_o
);
  localparam logic [DIVW-1:0] DIV_ONE = DIVW'(1);

  pm_mode_t mode_nxt;

  always_comb begin
    mode_nxt    = mode_q;
    halt_take_o = 1'b0;
    unique case (mode_q)
      MD_RUN:    if (!run_q) mode_nxt = MD_DIRECT;
      MD_DIRECT: begin
        if (armed_q) begin
          mode_nxt    = MD_HALT;
          halt_take_o = 1'b1;
        end else if (run_q && pll_en_q && pll_lock_i) begin
          mode_nxt = MD_RUN;
        end
      end
      MD_HALT:   if (wake_hit_i) mode_nxt = MD_DIRECT;
      default:   mode_nxt = MD_DIRECT;
    endcase
  end

  // outputs registered from the next mode so they move with mode_q
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q        <= MD_DIRECT;
      cpu_src_pll_o <= 1'b0;
      clk_gate_en_o <= 1'b1;
      sysclk_en_o   <= 1'b1;
      hdiv_o        <= DIV_ONE;
      pdiv_o        <= DIV_ONE;
    end else begin
      mode_q        <= mode_nxt;
      cpu_src_pll_o <= (mode_nxt == MD_RUN);
      clk_gate_en_o <= (mode_nxt != MD_HALT);
      sysclk_en_o   <= (mode_nxt != MD_HALT);
      hdiv_o        <= (mode_nxt == MD_RUN) ? hdiv_q : DIV_ONE;
      pdiv_o        <= (mode_nxt == MD_RUN) ? pdiv_q : DIV_ONE;
    end
  end

  AST_NO_RUN_TO_HALT: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_RUN) |=> (mode_q != MD_HALT)); // R2
  AST_NO_HALT_TO_RUN: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_HALT) |=> (mode_q != MD_RUN)); // R2
  AST_HALT_GATED: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_HALT) |-> (!clk_gate_en_o && !sysclk_en_o && !cpu_src_pll_o)); // R6
  AST_WAKE_TO_DIRECT: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_HALT && wake_hit_i) |=> (mode_q == MD_DIRECT)); // R7
  AST_RUN_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_DIRECT && !pll_lock_i) |=> (mode_q != MD_RUN)); // R9
  AST_RUN_USES_PLL: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_RUN) |-> (cpu_src_pll_o && clk_gate_en_o)); // R3
endmodule

// File: rtl/clkpm_ctrl.sv
module clkpm_ctrl
  import clkpm_pkg::*;
#(
  parameter int NWAKE    = 4,
  parameter int DIVW     = 4,
  parameter int DEF_HDIV = 2,
  parameter int DEF_PDIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic             ctl_run,
  input  logic             ctl_stop,
  input  logic             ctl_pll_on,
  input  logic [DIVW-1:0]  ctl_hdiv,
  input  logic [DIVW-1:0]  ctl_pdiv,
  output logic             run_rd,
  output logic             stop_rd,
  output logic             pll_en_o,
  input  logic             pll_lock_i,
  input  logic [NWAKE-1:0] wake_evt_i,
  input  logic [NWAKE-1:0] wake_en_i,
  output logic [1:0]       mode_o,
  output logic             cpu_src_pll_o,
  output logic             clk_gate_en_o,
  output logic             sysclk_en_o,
  output logic [DIVW-1:0]  hdiv_o,
  output logic [DIVW-1:0]  pdiv_o
);
  pm_mode_t        mode_q;
  logic            halt_take, armed_q, wake_hit;
  logic [DIVW-1:0] hdiv_q, pdiv_q;

  clkpm_ctl_regs #(.DIVW(DIVW), .DEF_HDIV(DEF_HDIV), .DEF_PDIV(DEF_PDIV)) u_regs (
    .clk(clk), .rst(rst), .we_i(ctl_we), .run_i(ctl_run), .stop_i(ctl_stop),
    .pll_i(ctl_pll_on), .hdiv_i(ctl_hdiv), .pdiv_i(ctl_pdiv), .mode_i(mode_q),
    .halt_take_i(halt_take), .run_q(run_rd), .stop_q(stop_rd), .armed_q(armed_q),
    .pll_en_q(pll_en_o), .hdiv_q(hdiv_q), .pdiv_q(pdiv_q)
  );

  clkpm_wake_det #(.NWAKE(NWAKE)) u_wake (
    .clk(clk), .rst(rst), .evt_i(wake_evt_i), .en_i(wake_en_i), .hit_o(wake_hit)
  );

  clkpm_mode_fsm #(.DIVW(DIVW)) u_fsm (
    .clk(clk), .rst(rst), .run_q(run_rd), .armed_q(armed_q), .pll_en_q(pll_en_o),
    .pll_lock_i(pll_lock_i), .wake_hit_i(wake_hit), .hdiv_q(hdiv_q), .pdiv_q(pdiv_q),
    .mode_q(mode_q), .halt_take_o(halt_take), .cpu_src_pll_o(cpu_src_pll_o),
    .clk_gate_en_o(clk_gate_en_o), .sysclk_en_o(sysclk_en_o),
    .hdiv_o(hdiv_o), .pdiv_o(pdiv_o)
  );

  assign mode_o = mode_q;
endmodule

// File: tb/sim_clkpm_ctrl.sv
`timescale 1ns/1ps
module sim_clkpm_ctrl;
  localparam int NWAKE = 4;
  localparam int DIVW  = 4;
  localparam int M_DIR = 0, M_RUN = 1, M_HALT = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic ctl_we = 0, ctl_run = 0, ctl_stop = 0, ctl_pll_on = 0;
  logic [DIVW-1:0] ctl_hdiv = '0, ctl_pdiv = '0;
  logic run_rd, stop_rd, pll_en_o, pll_lock_i;
  logic [NWAKE-1:0] wake_evt_i = '0, wake_en_i = '0;
  logic [1:0] mode_o;
  logic cpu_src_pll_o, clk_gate_en_o, sysclk_en_o;
  logic [DIVW-1:0] hdiv_o, pdiv_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic lock_block = 0;
  int lock_cnt = 0;
  logic lock_r = 0;

  always #2.5 clk = ~clk;

  clkpm_ctrl #(.NWAKE(NWAKE), .DIVW(DIVW)) u0 (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_run(ctl_run), .ctl_stop(ctl_stop),
    .ctl_pll_on(ctl_pll_on), .ctl_hdiv(ctl_hdiv), .ctl_pdiv(ctl_pdiv),
    .run_rd(run_rd), .stop_rd(stop_rd), .pll_en_o(pll_en_o), .pll_lock_i(pll_lock_i),
    .wake_evt_i(wake_evt_i), .wake_en_i(wake_en_i), .mode_o(mode_o),
    .cpu_src_pll_o(cpu_src_pll_o), .clk_gate_en_o(clk_gate_en_o),
    .sysclk_en_o(sysclk_en_o), .hdiv_o(hdiv_o), .pdiv_o(pdiv_o)
  );

  // PLL stub: lock a few cycles after enable, drop at once on disable
  always @(posedge clk) begin
    if (!pll_en_o || lock_block) begin
      lock_cnt <= 0;
      lock_r   <= 1'b0;
    end else if (lock_cnt < 3) lock_cnt <= lock_cnt + 1;
    else lock_r <= 1'b1;
  end
  assign pll_lock_i = lock_r;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic r, logic s, logic p, int hd, int pd);
    @(negedge clk);
    ctl_we = 1; ctl_run = r; ctl_stop = s; ctl_pll_on = p;
    ctl_hdiv = DIVW'(hd); ctl_pdiv = DIVW'(pd);
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic pulse(int idx);
    @(negedge clk);
    wake_evt_i[idx] = 1'b1;
    cyc(3);
    wake_evt_i[idx] = 1'b0;
  endtask

  // expected clock outputs for a mode
  function automatic int exp_src(int m); return (m == M_RUN) ? 1 : 0; endfunction
  function automatic int exp_gate(int m); return (m == M_HALT) ? 0 : 1; endfunction

  // bench model state for random phase
  int m_mode, m_armed;
  logic m_run, m_stop;

  function automatic void settle();
    for (int k = 0; k < 4; k++) begin
      if (m_mode == M_RUN && !m_run) m_mode = M_DIR;
      else if (m_mode == M_DIR && m_armed != 0) begin m_mode = M_HALT; m_armed = 0; end
      else if (m_mode == M_DIR && m_run) m_mode = M_RUN;
    end
  endfunction

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int prev, saw_direct, bad;
    void'($urandom(32'd20240611));
    cyc(4);
    rst = 1'b0;
    cyc(2);
    // R1 reset state, R4 direct-run outputs
    check("R1 mode", mode_o, M_DIR);
    check("R1 run", run_rd, 0);
    check("R1 stop", stop_rd, 0);
    check("R1 pll", pll_en_o, 0);
    check("R4 src", cpu_src_pll_o, 0);
    check("R4 gate", clk_gate_en_o, 1);
    check("R4 hdiv", hdiv_o, 1);

    // R9: run bit alone, PLL off
    wr(1, 0, 0, 3, 6);
    cyc(10);
    check("R9 no pll", mode_o, M_DIR);
    lock_block = 1;
    wr(1, 0, 1, 3, 6);
    cyc(10);
    check("R9 no lock", mode_o, M_DIR);
    check("R5 pll set in direct", pll_en_o, 1);
    lock_block = 0;
    cyc(10);
    check("R9 locked", mode_o, M_RUN);
    check("R3 src", cpu_src_pll_o, 1);
    check("R3 hdiv", hdiv_o, 3);
    check("R3 pdiv", pdiv_o, 6);

    // R5: fields frozen in run
    wr(1, 0, 0, 5, 7);
    cyc(6);
    check("R5 pll frozen", pll_en_o, 1);
    check("R5 hdiv frozen", hdiv_o, 3);
    check("R5 pdiv frozen", pdiv_o, 6);

    // R2/R8: leave run and halt in one write
    wr(0, 1, 1, 3, 6);
    bad = 0; saw_direct = 0; prev = M_RUN;
    for (int i = 0; i < 10; i++) begin
      if (prev == M_RUN && mode_o == M_HALT) bad = 1;
      if (mode_o == M_DIR) saw_direct = 1;
      prev = mode_o;
      cyc(1);
    end
    check("R2 no run->halt", bad, 0);
    check("R8 via direct", saw_direct, 1);
    check("R8 halted", mode_o, M_HALT);
    check("R6 gate", clk_gate_en_o, 0);
    check("R6 sysclk", sysclk_en_o, 0);
    check("R6 src", cpu_src_pll_o, 0);

    // R10: masked line
    wake_en_i = 4'b0001;
    pulse(1);
    cyc(8);
    check("R10 masked", mode_o, M_HALT);
    // R7: enabled line
    pulse(0);
    cyc(8);
    check("R7 wake", mode_o, M_DIR);
    check("R11 stop kept", stop_rd, 1);

    // R11: rewriting 1 does not re-arm
    wr(0, 1, 1, 3, 6);
    cyc(8);
    check("R11 no rearm", mode_o, M_DIR);
    // R10: level already high before halt entry
    wake_en_i = 4'b0101;
    @(negedge clk); wake_evt_i[2] = 1'b1;
    cyc(6);
    wr(0, 0, 1, 3, 6);
    wr(0, 1, 1, 3, 6);
    cyc(8);
    check("R11 rearm", mode_o, M_HALT);
    check("R10 held level", mode_o, M_HALT);
    @(negedge clk); wake_evt_i[2] = 1'b0;
    cyc(4);
    // R7 with run bit set: direct first, then run
    wr(1, 1, 1, 3, 6);
    cyc(4);
    check("R7 still halted", mode_o, M_HALT);
    pulse(2);
    saw_direct = 0; bad = 0; prev = M_HALT;
    for (int i = 0; i < 14; i++) begin
      if (prev == M_HALT && mode_o == M_RUN) bad = 1;
      if (mode_o == M_DIR) saw_direct = 1;
      prev = mode_o;
      cyc(1);
    end
    check("R2 no halt->run", bad, 0);
    check("R7 via direct", saw_direct, 1);
    check("R7 then run", mode_o, M_RUN);

    // R12: zero divisors ignored
    wr(0, 0, 1, 3, 6);
    cyc(4);
    check("R8 run cleared", mode_o, M_DIR);
    check("R4 pdiv", pdiv_o, 1);
    wr(1, 0, 1, 0, 0);
    cyc(10);
    check("R12 hdiv", hdiv_o, 3);
    check("R12 pdiv", pdiv_o, 6);

    // random phase against bench model
    wake_en_i = '1;
    m_mode = M_RUN; m_run = 1; m_stop = 0; m_armed = 0;
    for (int n = 0; n < 80; n++) begin
      if (($urandom % 3) != 0) begin
        logic r, s;
        r = 1'($urandom);
        s = 1'($urandom);
        if (s && !m_stop) m_armed = 1;
        if (!s) m_armed = 0;
        m_run = r; m_stop = s;
        wr(r, s, 1, 3, 6);
        settle();
      end else begin
        int idx;
        idx = int'($urandom % NWAKE);
        wake_en_i = 4'($urandom);
        pulse(idx);
        if (m_mode == M_HALT && wake_en_i[idx]) begin
          m_mode = M_DIR;
          settle();
        end
      end
      cyc(12);
      check("R8 rand mode", mode_o, m_mode);
      check("R11 rand stop", stop_rd, m_stop);
      check("R3 rand src", cpu_src_pll_o, exp_src(m_mode));
      check("R6 rand gate", clk_gate_en_o, exp_gate(m_mode));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule